// File: doc/BRIEF.md
# Sixteen-bit reload underflow timer

This block is a down-counter with a separate reload register. Each selected count tick lowers the counter by one. A tick that arrives while the counter already holds zero is an underflow. On an underflow the counter takes the reload value, a one-cycle request pulse goes out and a toggle output flips. The count tick comes from one of eight prescaled enable pulses, picked by a 3-bit select field, or from an external event input gated by a count window.

The bus register behaves asymmetrically. A write stores into the reload register, and a read returns the live counter. While the timer is stopped, a write also seeds the counter. A forced stop parks the counter at all-ones. Every full-width access stalls the bus for one cycle through a ready signal. A narrow access is ignored and does not stall.

A reload value of zero makes the counter underflow on every tick. For most tick sources this would flood the system with requests, so the block then issues a single request after start, while the toggle output keeps flipping.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the counter reads 0xFFFF, `req_pulse` and `tog_out` are 0, and `bus_ready` is 1.
- R2: A committed write stores `bus_wdata` into the reload register. `bus_rdata` always shows the live counter, so a write while running leaves the counter's sequence unchanged until the next underflow.
- R3: A committed write while `ctl_start` is 0 and `ctl_stop` is 0 also loads the written value into the counter on the same edge.
- R4: `ctl_stop` high forces the counter to 0xFFFF on the next edge and halts counting, regardless of `ctl_start`. It wins over a simultaneous write's counter load.
- R5: While `ctl_start` is 1 and `ctl_stop` is 0, outside event mode, a pulse on `tick_in[clk_sel]` lowers a nonzero counter by one on that edge.
- R6: A tick with the counter at 0 while running loads the reload value into the counter, flips `tog_out`, and raises `req_pulse` for exactly the following cycle. With a nonzero reload, every underflow gives a request.
- R7: With reload 0 and `clk_sel` other than 3'b001 (divide-by-8) or 3'b011 (divide-by-2), only the first underflow after `ctl_start` rises gives a request. Later underflows still flip `tog_out`. With select 3'b001 or 3'b011, every underflow gives a request.
- R8: With `evt_mode` 1, the tick is `evt_pulse` qualified by `evt_window`. With reload 0, every `evt_pulse` counts even outside the window, so `tog_out` flips on each one, and only one request follows start whatever `clk_sel` holds.
- R9: An access with `bus_sel` 1 and `bus_full` 0 is ignored. It changes neither register, and `bus_ready` stays 1.
- R10: A full access (`bus_sel` and `bus_full` held) sees `bus_ready` 0 in its first cycle and 1 in its second cycle. The write takes effect at the end of the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 16-bit access, 0 = narrow access (ignored) |
| bus_wdata | input | 16 | Write data for the reload register |
| bus_rdata | output | 16 | Live counter value |
| bus_ready | output | 1 | Low for the wait cycle of a full access |
| ctl_start | input | 1 | Count enable level |
| ctl_stop | input | 1 | Forced stop; parks counter at 0xFFFF |
| clk_sel | input | 3 | Tick source select (001 = divide-by-8, 011 = divide-by-2) |
| tick_in | input | 8 | One-cycle prescaled enable pulses, one per select code |
| evt_mode | input | 1 | 1 = count external events |
| evt_pulse | input | 1 | One-cycle external event pulse |
| evt_window | input | 1 | Event count window enable |
| req_pulse | output | 1 | One-cycle request on an underflow |
| tog_out | output | 1 | Output that flips on every underflow |

## Verification
The counter shows up directly on `bus_rdata`, so any wrong count, reload or stop value shows at the ports in the cycle after the faulty edge. A wrong first-request flag or zero-reload decision appears as a missing or extra `req_pulse` at the next underflow. A wrong wait-state flag shows as `bus_ready` off by one cycle within the same access. A reference model in the bench tracks every register and is compared with all outputs each cycle. Directed counts of requests and toggles cover the zero-reload modes.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
   localparam int RDT_W     = 16;
   localparam int RDT_SEL_W = 3;
   localparam logic [RDT_SEL_W-1:0] RDT_SEL_DIV8 = 3'b001;
   localparam logic [RDT_SEL_W-1:0] RDT_SEL_DIV2 = 3'b011;

   typedef struct packed {
      logic             commit;
      logic [RDT_W-1:0] data;
   } rdt_wr_t;
endpackage

// File: rtl/rdt_bus_port.sv
module rdt_bus_port #(
   parameter int W = rdt_pkg::RDT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_sel,
   input  logic         bus_wr,
   input  logic         bus_full,
   input  logic [W-1:0] bus_wdata,
   input  logic [W-1:0] cnt_val,
   output logic         bus_ready,
   output logic [W-1:0] bus_rdata,
   output logic         wr_commit,
   output logic [W-1:0] wr_data
);
   logic wait_q;
   logic full_acc;

   assign full_acc = bus_sel & bus_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= 1'b0;
      else        wait_q <= full_acc & ~wait_q;
   end

   assign bus_ready = ~(full_acc & ~wait_q);
   assign wr_commit = full_acc & wait_q & bus_wr;
   assign wr_data   = bus_wdata;
   assign bus_rdata = cnt_val;

   // R10
   one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ready && bus_sel && bus_full) |=> bus_ready);

   // R9
   narrow_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_full) |-> bus_ready);
endmodule

// File: rtl/rdt_tick_sel.sv
module rdt_tick_sel #(
   parameter int SEL_W  = rdt_pkg::RDT_SEL_W,
   parameter bit EVT_EN = 1'b1
) (
   input  logic [(1<<SEL_W)-1:0] tick_in,
   input  logic [SEL_W-1:0]      clk_sel,
   input  logic                  evt_mode,
   input  logic                  evt_pulse,
   input  logic                  evt_window,
   input  logic                  rel_zero,
   output logic                  tick
);
   generate
      if (EVT_EN) begin : g_evt
         assign tick = evt_mode ? (evt_pulse & (evt_window | rel_zero))
                                : tick_in[clk_sel];
      end else begin : g_noevt
         logic unused_evt;
         assign unused_evt = evt_mode ^ evt_pulse ^ evt_window ^ rel_zero;
         assign tick = tick_in[clk_sel];
      end
   endgenerate
endmodule

// File: rtl/rdt_count_core.sv
module rdt_count_core #(
   parameter int W = rdt_pkg::RDT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         stop,
   input  logic         tick,
   input  logic         one_shot_sel,
   input  logic         wr_commit,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] cnt,
   output logic         rel_zero,
   output logic         req,
   output logic         tog
);
   localparam logic [W-1:0] PARK = {W{1'b1}};
   localparam logic [W-1:0] ZERO = {W{1'b0}};

   logic [W-1:0] cnt_q, rel_q;
   logic         first_q, req_q, tog_q;
   logic         running, uf, one_shot;

   assign running  = start & ~stop;
   assign uf       = running & tick & (cnt_q == ZERO);
   assign one_shot = (rel_q == ZERO) & one_shot_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= PARK;
         rel_q   <= PARK;
         first_q <= 1'b0;
         req_q   <= 1'b0;
         tog_q   <= 1'b0;
      end else begin
         if (wr_commit) rel_q <= wr_data;

         if (stop)                       cnt_q <= PARK;
         else if (wr_commit && !start)   cnt_q <= wr_data;
         else if (uf)                    cnt_q <= rel_q;
         else if (running && tick)       cnt_q <= cnt_q - 1'b1;

         req_q <= uf & ~(one_shot & first_q);
         if (uf) tog_q <= ~tog_q;

         if (!running) first_q <= 1'b0;
         else if (uf)  first_q <= 1'b1;
      end
   end

   assign cnt      = cnt_q;
   assign rel_zero = (rel_q == ZERO);
   assign req      = req_q;
   assign tog      = tog_q;

   // R4
   stop_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (cnt_q == PARK));

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R6
   reload_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> (cnt_q == $past(rel_q)));

   // R6
   req_with_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (tog_q != $past(tog_q)));
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
   parameter int                        CNT_W     = rdt_pkg::RDT_W,
   parameter int                        SEL_W     = rdt_pkg::RDT_SEL_W,
   parameter logic [SEL_W-1:0]          FAST_A    = rdt_pkg::RDT_SEL_DIV8,
   parameter logic [SEL_W-1:0]          FAST_B    = rdt_pkg::RDT_SEL_DIV2,
   parameter bit                        EVT_EN    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic                   bus_full,
   input  logic [CNT_W-1:0]       bus_wdata,
   output logic [CNT_W-1:0]       bus_rdata,
   output logic                   bus_ready,
   input  logic                   ctl_start,
   input  logic                   ctl_stop,
   input  logic [SEL_W-1:0]       clk_sel,
   input  logic [(1<<SEL_W)-1:0]  tick_in,
   input  logic                   evt_mode,
   input  logic                   evt_pulse,
   input  logic                   evt_window,
   output logic                   req_pulse,
   output logic                   tog_out
);
   localparam int NUM_TICKS = 1 << SEL_W;

   if (CNT_W < 2) begin : g_bad_width
      $error("reload_down_timer: CNT_W must be at least 2");
   end
   if (FAST_A == FAST_B) begin : g_bad_fast
      $error("reload_down_timer: FAST_A and FAST_B must differ");
   end
   if (NUM_TICKS < 2) begin : g_bad_sel
      $error("reload_down_timer: SEL_W must give at least two tick sources");
   end

   logic [CNT_W-1:0] cnt;
   logic             wr_commit;
   logic [CNT_W-1:0] wr_data;
   logic             tick;
   logic             rel_zero;
   logic             one_shot_sel;
   logic             fast_sel;

   assign fast_sel     = (clk_sel == FAST_A) | (clk_sel == FAST_B);
   assign one_shot_sel = (EVT_EN & evt_mode) | ~fast_sel;

   rdt_bus_port #(.W(CNT_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_full  (bus_full),
      .bus_wdata (bus_wdata),
      .cnt_val   (cnt),
      .bus_ready (bus_ready),
      .bus_rdata (bus_rdata),
      .wr_commit (wr_commit),
      .wr_data   (wr_data)
   );

   rdt_tick_sel #(.SEL_W(SEL_W), .EVT_EN(EVT_EN)) u_tick (
      .tick_in    (tick_in),
      .clk_sel    (clk_sel),
      .evt_mode   (evt_mode),
      .evt_pulse  (evt_pulse),
      .evt_window (evt_window),
      .rel_zero   (rel_zero),
      .tick       (tick)
   );

   rdt_count_core #(.W(CNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (ctl_start),
      .stop         (ctl_stop),
      .tick         (tick),
      .one_shot_sel (one_shot_sel),
      .wr_commit    (wr_commit),
      .wr_data      (wr_data),
      .cnt          (cnt),
      .rel_zero     (rel_zero),
      .req          (req_pulse),
      .tog          (tog_out)
   );

   // R3
   stopped_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_full && bus_wr && bus_ready && !ctl_start && !ctl_stop
       && $past(bus_sel && bus_full && !bus_ready))
      |=> (bus_rdata == $past(bus_wdata)));

   // R6
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_pulse && !ctl_start) |=> !req_pulse);
endmodule

// File: tb/sim_reload_down_timer.sv
module sim_reload_down_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_full = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        bus_ready;
   logic        ctl_start = 1'b0, ctl_stop = 1'b0;
   logic [2:0]  clk_sel = 3'd0;
   logic [7:0]  tick_in = 8'h0;
   logic        evt_mode = 1'b0, evt_pulse = 1'b0, evt_window = 1'b0;
   logic        req_pulse, tog_out;

   always #2 clk = ~clk;

   reload_down_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_full(bus_full), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
      .clk_sel(clk_sel), .tick_in(tick_in), .evt_mode(evt_mode),
      .evt_pulse(evt_pulse), .evt_window(evt_window),
      .req_pulse(req_pulse), .tog_out(tog_out)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   int n_req = 0, n_tog = 0;
   logic prev_tog = 1'b0;
   bit   tick_en = 1'b0;

   // reference model state
   logic [15:0] m_cnt = 16'hFFFF, m_rel = 16'hFFFF;
   logic        m_tog = 1'b0, m_req = 1'b0, m_first = 1'b0, m_wait = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // prescaled ticks: source i pulses every i+2 cycles
   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < 8; i++)
         tick_in[i] <= tick_en && (cyc % (i + 2) == 0);
   end

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 16'hFFFF; m_rel = 16'hFFFF; m_tog = 0; m_req = 0;
         m_first = 0; m_wait = 0;
      end else begin
         bit run, tk, zero_one, uf, wcommit;
         logic [15:0] old_rel;
         run = ctl_start && !ctl_stop;
         wcommit = bus_sel && bus_full && bus_wr && m_wait;
         tk = evt_mode ? (evt_pulse && (evt_window || m_rel == 0)) : tick_in[clk_sel];
         zero_one = (m_rel == 0) && (evt_mode || !(clk_sel == 3'b001 || clk_sel == 3'b011));
         uf = run && tk && (m_cnt == 0);
         old_rel = m_rel;
         m_req = uf && !(zero_one && m_first);
         m_wait = bus_sel && bus_full && !m_wait;
         if (wcommit) m_rel = bus_wdata;
         if (ctl_stop)                     m_cnt = 16'hFFFF;
         else if (wcommit && !ctl_start)   m_cnt = bus_wdata;
         else if (uf)                      m_cnt = old_rel;
         else if (run && tk)               m_cnt = m_cnt - 1;
         if (uf) m_tog = !m_tog;
         if (!run) m_first = 0; else if (uf) m_first = 1;
      end
   end

   // per-cycle comparison, sampled 1 ns after the falling edge
   always begin
      @(negedge clk); #1;
      if (rst_n) begin
         chk(req_pulse == m_req, "R6 req_pulse", req_pulse, m_req);
         chk(tog_out == m_tog, "R6 tog_out", tog_out, m_tog);
         chk(bus_rdata == m_cnt, "R2 bus_rdata", bus_rdata, m_cnt);
         chk(bus_ready == !(bus_sel && bus_full && !m_wait), "R10 bus_ready",
             bus_ready, !(bus_sel && bus_full && !m_wait));
         if (req_pulse) n_req++;
         if (tog_out != prev_tog) n_tog++;
         prev_tog = tog_out;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic full_access(input bit wr, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_full = 1; bus_wr = wr; bus_wdata = d;
      #1 chk(bus_ready == 1'b0, "R10 wait cycle", bus_ready, 0);
      @(negedge clk);
      #1 chk(bus_ready == 1'b1, "R10 ready cycle", bus_ready, 1);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_full = 0;
   endtask

   task automatic evt(input bit win);
      @(negedge clk); evt_pulse = 1; evt_window = win;
      @(negedge clk); evt_pulse = 0; evt_window = 0;
   endtask

   initial begin
      cycles(3);
      #1 chk(bus_rdata == 16'hFFFF, "R1 counter reset", bus_rdata, 16'hFFFF);
      chk(req_pulse == 0 && tog_out == 0, "R1 outputs reset", {req_pulse, tog_out}, 0);
      chk(bus_ready == 1, "R1 ready reset", bus_ready, 1);
      @(negedge clk); rst_n = 1; tick_en = 1;

      // R3: write while stopped seeds the counter
      full_access(1, 16'd5);
      #1 chk(bus_rdata == 16'd5, "R3 seed on stopped write", bus_rdata, 5);

      // R5/R6: count with source 2 (every 4 cycles)
      clk_sel = 3'd2; ctl_start = 1; n_req = 0;
      cycles(60);
      chk(n_req >= 2, "R6 requests with nonzero reload", n_req, 2);

      // R2: write while running alters only the reload
      full_access(1, 16'd2);
      #1 chk(bus_rdata == m_cnt && bus_rdata != 16'd2 || m_cnt == 2,
             "R2 write leaves counter", bus_rdata, m_cnt);
      full_access(0, 16'h0);
      cycles(40);

      // R4: forced stop parks at all-ones
      @(negedge clk); ctl_stop = 1;
      @(negedge clk); ctl_stop = 0;
      #1 chk(bus_rdata == 16'hFFFF, "R4 stop parks counter", bus_rdata, 16'hFFFF);
      @(negedge clk); ctl_stop = 1; cycles(6);
      #1 chk(bus_rdata == 16'hFFFF, "R4 counting halted", bus_rdata, 16'hFFFF);
      @(negedge clk); ctl_stop = 0; ctl_start = 0;

      // R9: narrow access ignored
      @(negedge clk); bus_sel = 1; bus_full = 0; bus_wr = 1; bus_wdata = 16'h1234;
      #1 chk(bus_ready == 1, "R9 no wait on narrow", bus_ready, 1);
      @(negedge clk); bus_sel = 0; bus_wr = 0;
      #1 chk(bus_rdata == 16'hFFFF, "R9 narrow write ignored", bus_rdata, 16'hFFFF);

      // R7: zero reload, slow source -> one request
      full_access(1, 16'd0);
      clk_sel = 3'd5; n_req = 0; n_tog = 0; ctl_start = 1;
      cycles(100);
      chk(n_req == 1, "R7 single request", n_req, 1);
      chk(n_tog > 5, "R7 toggles continue", n_tog, 6);
      ctl_start = 0; cycles(2);

      // R7: divide-by-8 and divide-by-2 selections request every underflow
      clk_sel = 3'b001; n_req = 0; ctl_start = 1;
      cycles(30);
      chk(n_req > 5, "R7 div8 code repeats", n_req, 6);
      ctl_start = 0; cycles(2);
      clk_sel = 3'b011; n_req = 0; ctl_start = 1;
      cycles(30);
      chk(n_req > 3, "R7 div2 code repeats", n_req, 4);
      ctl_start = 0; cycles(2);

      // R8: event mode, reload 2
      evt_mode = 1; clk_sel = 3'b001;
      full_access(1, 16'd2);
      ctl_start = 1; n_req = 0;
      evt(0); evt(0);
      #1 chk(bus_rdata == 16'd2, "R8 outside window no count", bus_rdata, 2);
      for (int k = 0; k < 9; k++) evt(1);
      cycles(2);
      chk(n_req == 3, "R8 event requests", n_req, 3);
      ctl_start = 0;

      // R8: event mode, reload 0, toggles outside window, one request
      full_access(1, 16'd0);
      ctl_start = 1; n_req = 0; n_tog = 0;
      for (int k = 0; k < 5; k++) evt(0);
      cycles(2);
      chk(n_req == 1, "R8 zero reload single request", n_req, 1);
      chk(n_tog == 5, "R8 toggles outside window", n_tog, 5);
      ctl_start = 0; evt_mode = 0;
      cycles(5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule